// File: doc/BRIEF.md
# Event Log Ring Writer

This block is the producing side of a circular event log that lives in system memory. Translation and command-processing logic hand it fault and error records over a valid/ready port. The block formats each record as a 16-byte entry, writes it through a simple single-request memory write port at the current tail slot, and moves the tail forward once the memory side acknowledges the write.

Software drains the log. After it reads entries, it writes its consumer index into the block, which frees those slots. The block compares its tail with that consumer index to tell when the ring is full. A record that arrives while the ring is full is accepted and thrown away, and a sticky overflow flag records the loss. An optional interrupt pulse marks every entry that lands in memory.

The ring holds up to 2^IDX_W entries. The default of 32768 entries gives a 512 KB log. The active length is a run-time input, and the tail wraps to slot zero when it reaches that length.

Top module: `evlog_ring_writer`

## Requirements
- R1: While reset is high and in the cycle after it, tail_idx is 0, ovf is 0, irq is 0, mem_req is 0 and ev_ready is 1. The software consumer index also resets to 0.
- R2: ev_ready is 1 while no memory write is outstanding. An accepted record that is not dropped raises mem_req in the next cycle. ev_ready stays 0 from then until the cycle after mem_ack, so records are written in arrival order.
- R3: The entry address is the ring base, with its low four bits forced to zero, plus 16 times the tail index at the time the record was accepted.
- R4: The entry layout is fixed. Bits [2:0] hold the event kind code. Bits [15:3] are zero. Bits [31:16] hold the 16-bit source identifier. Bits [95:32] hold the 64-bit faulting address. Bits [127:96] are zero. The kind codes are: 0 bad device-table entry, 1 page fault, 2 device-table hardware error, 3 page-table hardware error, 4 malformed device request, 5 command hardware error, 6 unknown command, 7 remote-cache invalidation timeout.
- R5: Once mem_req is raised, it stays high with mem_addr and mem_data unchanged until a cycle in which mem_ack is 1.
- R6: On a cycle with mem_req and mem_ack both high, tail_idx advances by one, visible in the next cycle. It wraps to 0 when the incremented value reaches cfg_len.
- R7: A software write of the consumer index (head_wr high) takes effect on the full test in the cycle after the write.
- R8: The ring is full when the advanced tail would equal the consumer index. A record accepted while the ring is full produces no memory write and leaves tail_idx unchanged.
- R9: ovf becomes 1 in the cycle after a record is dropped and stays 1 until reset.
- R10: With irq_en high, irq is a one-cycle pulse in the cycle after each acknowledged write. With irq_en low, or for a dropped record, irq stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | MEM_AW | Ring base byte address; low 4 bits ignored |
| cfg_len | input | IDX_W+1 | Ring length in entries |
| irq_en | input | 1 | Per-entry interrupt enable |
| head_wr | input | 1 | Software write strobe for the consumer index |
| head_val | input | IDX_W | New consumer index |
| ev_valid | input | 1 | Record offered |
| ev_ready | output | 1 | Record can be taken |
| ev_type | input | 3 | Event kind code |
| ev_src | input | 16 | Source identifier of the failing request |
| ev_addr | input | 64 | Address associated with the event |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | MEM_AW | Byte address of the entry |
| mem_data | output | 128 | Formatted 16-byte entry |
| mem_ack | input | 1 | Memory write accepted |
| tail_idx | output | IDX_W | Producer index |
| irq | output | 1 | Entry-written interrupt pulse |
| ovf | output | 1 | Sticky overflow flag |

## Verification
A wrong tail or a wrong consumer index shows up on the very next record. The entry address moves to the wrong slot at once. The full test also fires one record too early or too late, which shows as a missing memory request or a spurious overflow. A controller stuck in its write state shows as ev_ready held low and no further requests. The sweep covers every ring length from 2 to 8 on a small index width, with wrap-around, repeated fill-to-full and drains of different sizes, so each pointer fault becomes visible within a few records.

// File: rtl/evlog_pkg.sv
package evlog_pkg;

    localparam int ENTRY_W = 128;
    localparam int OFS_W   = 4;
    localparam int SRC_W   = 16;
    localparam int VA_W    = 64;
    localparam int KIND_W  = 3;

    typedef enum logic [KIND_W-1:0] {
        EVK_DEVENT_BAD  = 3'd0,
        EVK_PAGE_FAULT  = 3'd1,
        EVK_DEVTAB_HW   = 3'd2,
        EVK_PGTAB_HW    = 3'd3,
        EVK_REQ_BAD     = 3'd4,
        EVK_CMD_HW      = 3'd5,
        EVK_CMD_UNKNOWN = 3'd6,
        EVK_INVAL_TMO   = 3'd7
    } ev_kind_e;

    typedef struct packed {
        ev_kind_e             kind;
        logic [SRC_W-1:0]     src;
        logic [VA_W-1:0]      addr;
    } ev_rec_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } wr_state_e;

    function automatic logic [ENTRY_W-1:0] pack_entry(input ev_rec_t r);
        logic [ENTRY_W-1:0] e;
        e        = '0;
        e[2:0]   = r.kind;
        e[31:16] = r.src;
        e[95:32] = r.addr;
        return e;
    endfunction

endpackage

// File: rtl/evlog_ptr.sv
module evlog_ptr #(
    parameter int IDX_W = 15,
    localparam int LEN_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             head_wr,
    input  logic [IDX_W-1:0] head_val,
    input  logic             adv,
    output logic [IDX_W-1:0] tail,
    output logic             full
);

    logic [IDX_W-1:0] tail_q;
    logic [IDX_W-1:0] head_q;
    logic [IDX_W-1:0] tail_nx;
    logic [LEN_W-1:0] tail_inc;

    always_comb begin
        tail_inc = {1'b0, tail_q} + LEN_W'(1);
        tail_nx  = (tail_inc >= cfg_len) ? '0 : tail_inc[IDX_W-1:0];
        full     = (tail_nx == head_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tail_q <= '0;
            head_q <= '0;
        end else begin
            if (head_wr) head_q <= head_val;
            if (adv)     tail_q <= tail_nx;
        end
    end

    assign tail = tail_q;

    // R6
    tail_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_len != '0) |-> ({1'b0, tail_q} < cfg_len));

    // R8
    no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
        adv |=> (tail_q != $past(head_q)));

endmodule

// File: rtl/evlog_fmt.sv
module evlog_fmt
    import evlog_pkg::*;
#(
    parameter int MEM_AW = 48,
    parameter int IDX_W  = 15
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cap,
    input  logic [MEM_AW-1:0]  base,
    input  logic [IDX_W-1:0]   tail,
    input  ev_rec_t            rec,
    output logic [MEM_AW-1:0]  addr,
    output logic [ENTRY_W-1:0] data
);

    logic [MEM_AW-1:0] base_al;
    logic [MEM_AW-1:0] slot_ofs;

    always_comb begin
        base_al  = base & ~MEM_AW'((1 << OFS_W) - 1);
        slot_ofs = MEM_AW'(tail) << OFS_W;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            data <= '0;
        end else if (cap) begin
            addr <= base_al + slot_ofs;
            data <= pack_entry(rec);
        end
    end

    // R3
    entry_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        $past(cap) |-> (addr[OFS_W-1:0] == '0));

endmodule

// File: rtl/evlog_ctl.sv
module evlog_ctl
    import evlog_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ev_valid,
    input  logic full,
    input  logic mem_ack,
    input  logic irq_en,
    output logic ev_ready,
    output logic cap,
    output logic adv,
    output logic mem_req,
    output logic irq,
    output logic ovf
);

    wr_state_e st_q;
    logic      take;
    logic      drop;
    logic      irq_q;
    logic      ovf_q;

    always_comb begin
        ev_ready = (st_q == ST_IDLE);
        take     = ev_valid && ev_ready;
        cap      = take && !full;
        drop     = take && full;
        mem_req  = (st_q == ST_WRITE);
        adv      = mem_req && mem_ack;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            irq_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE:  if (cap) st_q <= ST_WRITE;
                ST_WRITE: if (mem_ack) st_q <= ST_IDLE;
                default:  st_q <= ST_IDLE;
            endcase
            irq_q <= adv && irq_en;
            if (drop) ovf_q <= 1'b1;
        end
    end

    assign irq = irq_q;
    assign ovf = ovf_q;

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> mem_req);

    // R10
    irq_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> $past(mem_ack && mem_req));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);

    // R8
    drop_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        drop |=> !mem_req);

endmodule

// File: rtl/evlog_ring_writer.sv
module evlog_ring_writer
    import evlog_pkg::*;
#(
    parameter int MEM_AW = 48,
    parameter int IDX_W  = 15,
    localparam int LEN_W = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [MEM_AW-1:0]  cfg_base,
    input  logic [LEN_W-1:0]   cfg_len,
    input  logic               irq_en,
    input  logic               head_wr,
    input  logic [IDX_W-1:0]   head_val,
    input  logic               ev_valid,
    output logic               ev_ready,
    input  logic [2:0]         ev_type,
    input  logic [15:0]        ev_src,
    input  logic [63:0]        ev_addr,
    output logic               mem_req,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic [127:0]       mem_data,
    input  logic               mem_ack,
    output logic [IDX_W-1:0]   tail_idx,
    output logic               irq,
    output logic               ovf
);

    ev_rec_t          rec;
    logic             full;
    logic             cap;
    logic             adv;
    logic [IDX_W-1:0] tail;

    always_comb begin
        rec.kind = ev_kind_e'(ev_type);
        rec.src  = ev_src;
        rec.addr = ev_addr;
    end

    evlog_ptr #(.IDX_W(IDX_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .cfg_len  (cfg_len),
        .head_wr  (head_wr),
        .head_val (head_val),
        .adv      (adv),
        .tail     (tail),
        .full     (full)
    );

    evlog_fmt #(.MEM_AW(MEM_AW), .IDX_W(IDX_W)) u_fmt (
        .clk  (clk),
        .rst  (rst),
        .cap  (cap),
        .base (cfg_base),
        .tail (tail),
        .rec  (rec),
        .addr (mem_addr),
        .data (mem_data)
    );

    evlog_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .ev_valid (ev_valid),
        .full     (full),
        .mem_ack  (mem_ack),
        .irq_en   (irq_en),
        .ev_ready (ev_ready),
        .cap      (cap),
        .adv      (adv),
        .mem_req  (mem_req),
        .irq      (irq),
        .ovf      (ovf)
    );

    assign tail_idx = tail;

    // R5
    entry_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_data)));

    // R2
    busy_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> !ev_ready);

endmodule

// File: tb/evlog_ring_writer_bench.sv
`timescale 1ns/1ps
module evlog_ring_writer_bench;

    localparam int AW = 48;
    localparam int IW = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [AW-1:0]  cfg_base = '0;
    logic [IW:0]    cfg_len = 4'd8;
    logic           irq_en = 1'b0;
    logic           head_wr = 1'b0;
    logic [IW-1:0]  head_val = '0;
    logic           ev_valid = 1'b0;
    logic           ev_ready;
    logic [2:0]     ev_type = '0;
    logic [15:0]    ev_src = '0;
    logic [63:0]    ev_addr = '0;
    logic           mem_req;
    logic [AW-1:0]  mem_addr;
    logic [127:0]   mem_data;
    logic           mem_ack = 1'b0;
    logic [IW-1:0]  tail_idx;
    logic           irq;
    logic           ovf;

    int n_chk  = 0;
    int n_fail = 0;
    int L, et, eh;
    bit eo;

    always #2 clk = ~clk;

    evlog_ring_writer #(.MEM_AW(AW), .IDX_W(IW)) u_evlog_ring_writer (
        .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_len(cfg_len),
        .irq_en(irq_en), .head_wr(head_wr), .head_val(head_val),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_type(ev_type),
        .ev_src(ev_src), .ev_addr(ev_addr), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack),
        .tail_idx(tail_idx), .irq(irq), .ovf(ovf)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s (len %0d) act=%0h exp=%0h", tag, L, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        // R1: reset values while reset is held
        chk(tail_idx == '0, "R1 tail in reset", 128'(tail_idx), 0);
        chk(mem_req == 1'b0, "R1 mem_req in reset", 128'(mem_req), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(tail_idx == '0, "R1 tail", 128'(tail_idx), 0);
        chk(ovf == 1'b0, "R1 ovf", 128'(ovf), 0);
        chk(irq == 1'b0, "R1 irq", 128'(irq), 0);
        chk(mem_req == 1'b0, "R1 mem_req", 128'(mem_req), 0);
        chk(ev_ready == 1'b1, "R1 ev_ready", 128'(ev_ready), 1);
        et = 0;
        eh = 0;
        eo = 1'b0;
    endtask

    task automatic move_head(input int k);
        eh = (eh + k) % L;
        head_val = IW'(eh);
        head_wr = 1'b1;
        @(negedge clk);
        head_wr = 1'b0;
    endtask

    task automatic send_ev(input int k, input int dly);
        logic [127:0] expd;
        logic [AW-1:0] expa;
        bit full_e;
        full_e   = (((et + 1) % L) == eh);
        ev_valid = 1'b1;
        ev_type  = k[2:0];
        ev_src   = 16'(16'hA000 + k);
        ev_addr  = {32'(32'h1234_0000 + k), 32'(32'hBEEF_0000 ^ k)};
        expd = {32'h0, ev_addr, ev_src, 13'h0, ev_type};
        expa = (cfg_base & ~AW'(15)) + AW'(et) * AW'(16);
        chk(ev_ready == 1'b1, "R2 ready when idle", 128'(ev_ready), 1);
        @(negedge clk);
        ev_valid = 1'b0;
        if (full_e) begin
            // R8: dropped record writes nothing and leaves the tail alone
            chk(mem_req == 1'b0, "R8 no write when full", 128'(mem_req), 0);
            chk(tail_idx == IW'(et), "R8 tail kept when full", 128'(tail_idx), 128'(et));
            // R9: overflow raised by the drop
            chk(ovf == 1'b1, "R9 ovf set on drop", 128'(ovf), 1);
            chk(irq == 1'b0, "R10 no irq on drop", 128'(irq), 0);
            eo = 1'b1;
        end else begin
            chk(mem_req == 1'b1, "R2 request follows accept", 128'(mem_req), 1);
            chk(mem_addr == expa, "R3 entry address", 128'(mem_addr), 128'(expa));
            chk(mem_data == expd, "R4 entry layout", mem_data, expd);
            for (int d = 0; d < dly; d++) begin
                chk(ev_ready == 1'b0, "R2 ready low while busy", 128'(ev_ready), 0);
                @(negedge clk);
                chk(mem_req == 1'b1, "R5 request held", 128'(mem_req), 1);
                chk(mem_addr == expa, "R5 address held", 128'(mem_addr), 128'(expa));
                chk(mem_data == expd, "R5 data held", mem_data, expd);
            end
            mem_ack = 1'b1;
            @(negedge clk);
            mem_ack = 1'b0;
            et = (et + 1) % L;
            chk(tail_idx == IW'(et), "R6 tail advance and wrap", 128'(tail_idx), 128'(et));
            chk(irq == irq_en, "R10 irq after ack", 128'(irq), 128'(irq_en));
            chk(mem_req == 1'b0, "R5 request ends on ack", 128'(mem_req), 0);
            chk(ev_ready == 1'b1, "R2 ready after ack", 128'(ev_ready), 1);
            @(negedge clk);
            chk(irq == 1'b0, "R10 irq one cycle", 128'(irq), 0);
            chk(ovf == eo, "R9 ovf sticky", 128'(ovf), 128'(eo));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int len = 2; len <= 8; len++) begin
            L = len;
            cfg_len  = 4'(len);
            cfg_base = AW'(48'h0000_8000_0000) + AW'(len) * AW'(48'h1000) + AW'(len + 3);
            irq_en   = len[0];
            do_reset();
            for (int it = 0; it < 4 * len; it++) begin
                // R7: freeing slots through a consumer index write
                if ((it % 3) == 2) begin
                    int occ;
                    occ = (et - eh + L) % L;
                    if (occ > 0) move_head((occ > 1 && it[0]) ? 2 : 1);
                end
                send_ev(it + len * 8, it % 3);
            end
            if (len == 8) begin
                do_reset();
                chk(ovf == 1'b0, "R9 ovf cleared by reset", 128'(ovf), 0);
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule